// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block takes a parallel word and sends it out one bit at a time. An active-low load input copies the parallel word into all stages. It does this at once, without waiting for a clock edge, and it overrides every other input. While the load input is released, each rising clock edge moves the contents one stage toward the highest stage, but only if the active-low shift enable is low. A new bit enters stage 0 from the serial input.

The highest stage drives the serial output, together with its complement. After a load, the word therefore leaves most-significant bit first. The bits shifted in from the serial input follow it in arrival order, so one register can feed another. There is no reset pin. All stages are cleared by loading an all-zero word.

Top module: `piso_shreg`

## Requirements
- R1: Stages are numbered 0 to WIDTH-1 and par_word bit k maps to stage k. When load_n falls, par_word is copied into the stages at once. serial_out then shows par_word[WIDTH-1] before any rising clock edge.
- R2: While load_n is low, a rising clock edge does not shift, whatever hold_n and serial_in are. The stages keep the loaded word.
- R3: If load_n is high and hold_n is low, each rising clock edge moves stage k into stage k+1. After a load, serial_out presents par_word[WIDTH-1], then par_word[WIDTH-2], and so on down to par_word[0], one bit per shifting edge.
- R4: On each shifting edge, serial_in is captured into stage 0. It reaches serial_out WIDTH-1 shifting edges later.
- R5: If load_n is high and hold_n is high, a rising clock edge leaves every stage unchanged, and serial_out does not change.
- R6: serial_out_n is always the logical inverse of serial_out.
- R7: Loading an all-zero word clears every stage. WIDTH shifts with serial_in low then yield only zeros on serial_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| load_n | input | 1 | Asynchronous parallel load, active low |
| par_word | input | WIDTH | Parallel word, bit k goes to stage k |
| serial_in | input | 1 | Bit entering stage 0 on each shift |
| hold_n | input | 1 | Shift enable, active low; high holds |
| serial_out | output | 1 | Content of stage WIDTH-1 |
| serial_out_n | output | 1 | Inverse of serial_out |

## Verification
The bench samples serial_out one nanosecond after the load falls, well before the next clock edge. A design that waits for the clock to load would still show the old bit at that point. Each load pulse spans a clock edge while shifting is enabled. A design that lets shifting win over the load would move the word along during the pulse and show the wrong first bit.

The bench then shifts random words out with random hold patterns and random serial input. A design that reverses the direction, ignores hold, or drops the serial input would send out bits in the wrong order, or lose the bits that follow the word. An all-zero load followed by a full drain catches a design that clears only some of the stages. The complement output is compared on every sample.

// File: rtl/piso_shreg.sv
module piso_shreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             load_n,
  input  logic [WIDTH-1:0] par_word,
  input  logic             serial_in,
  input  logic             hold_n,
  output logic             serial_out,
  output logic             serial_out_n
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] stages;

  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n)
      stages <= par_word;
    else if (!hold_n)
      stages <= {stages[TOP-1:0], serial_in};
  end

  assign serial_out   = stages[TOP];
  assign serial_out_n = ~stages[TOP];

  // load captures the applied word while asserted
  p_load_r1: assert property (@(posedge clk)
    (!load_n && $stable(par_word)) |-> (stages == par_word));

  // no shift across an edge that saw the load held low
  p_prio_r2: assert property (@(posedge clk)
    (!$past(load_n) && !load_n) |-> (stages == par_word));

  p_shift_r3: assert property (@(posedge clk) disable iff (!load_n)
    ($past(load_n) && !$past(hold_n)) |-> (stages[TOP:1] == $past(stages[TOP-1:0])));

  p_entry_r4: assert property (@(posedge clk) disable iff (!load_n)
    ($past(load_n) && !$past(hold_n)) |-> (stages[0] == $past(serial_in)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!load_n)
    ($past(load_n) && $past(hold_n)) |-> (stages == $past(stages)));
endmodule

// File: tb/test_piso_shreg.sv
module test_piso_shreg;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         load_n = 1'b1;
  logic [W-1:0] par_word = '0;
  logic         serial_in = 1'b0;
  logic         hold_n = 1'b1;
  logic         serial_out, serial_out_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [W-1:0] model;

  always #4 clk = ~clk;

  piso_shreg #(.WIDTH(W)) i_piso_shreg (
    .clk(clk), .load_n(load_n), .par_word(par_word), .serial_in(serial_in),
    .hold_n(hold_n), .serial_out(serial_out), .serial_out_n(serial_out_n)
  );

  function automatic logic [W-1:0] next_model(logic [W-1:0] cur, logic hn, logic si);
    return hn ? cur : {cur[W-2:0], si};
  endfunction

  task automatic check_out(string req, logic exp);
    checks++;
    if (serial_out !== exp) begin
      errors++;
      $display("FAIL %s serial_out actual %b expected %b", req, serial_out, exp);
    end
    checks++;
    if (serial_out_n !== ~exp) begin
      errors++;
      $display("FAIL R6 serial_out_n actual %b expected %b", serial_out_n, ~exp);
    end
  endtask

  // load pulse spanning one rising edge, with shifting enabled during it
  task automatic do_load(logic [W-1:0] v);
    @(negedge clk);
    par_word = v;
    hold_n = 1'b0;
    serial_in = ~v[W-1];
    load_n = 1'b0;
    #1;
    check_out("R1", v[W-1]);
    @(negedge clk);
    check_out("R2", v[W-1]);
    load_n = 1'b1;
    model = v;
    #1;
    check_out("R2", v[W-1]);
  endtask

  task automatic step(logic hn, logic si, string req);
    hold_n = hn;
    serial_in = si;
    @(negedge clk);
    model = next_model(model, hn, si);
    check_out(req, model[W-1]);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    #2;
    // reset state: load 0xA5 at start
    do_load(8'hA5);
    // R3 directed: bits leave MSB first
    for (int k = 0; k < W; k++) step(1'b0, 1'b0, "R3");
    // R4: bits shifted in during drain emerge next
    do_load(8'h00);
    for (int k = 0; k < W; k++) step(1'b0, k[0], "R4");
    for (int k = 0; k < W; k++) step(1'b0, 1'b0, "R4");
    // R5: hold across several edges
    do_load(8'h3C);
    for (int k = 0; k < 5; k++) step(1'b1, 1'b1, "R5");
    for (int k = 0; k < W; k++) step(1'b0, 1'b1, "R3");
    // R7: clear by loading zeros
    do_load(8'hFF);
    do_load(8'h00);
    for (int k = 0; k < W; k++) step(1'b0, 1'b0, "R7");
    // random mix
    for (int n = 0; n < 40; n++) begin
      do_load(W'($urandom));
      for (int k = 0; k < 2 * W + 4; k++)
        step(($urandom % 4) == 0, 1'($urandom), "R3");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule